// File: doc/BRIEF.md
# USB Host Controller Operational Register Bank

This block holds the 32-bit operational registers of an OHCI-style USB host controller behind a plain read/write port. The byte address is turned into a word index, and each index has its own write rule. Some registers accept stored bits under a mask. Status bits are cleared by writing a 1. The interrupt mask is reached through a separate set alias and a separate clear alias. Command bits are set by writing a 1. A few registers are read-only mirrors of values that other logic supplies.

Read data is combinational from the address. Writes take effect at the rising clock edge where `we_i` is high. A level interrupt is derived from the stored status and the mask. The host-controller-functional-state field of the control register is exported. Writing the reset command bit returns the whole bank to its reset values and produces a one-cycle soft-reset pulse for the rest of the controller.

Frame timing, list processing and root-hub port logic sit outside this block. They feed it with event pulses, read-only register values and port status words.

Top module: `usb_hc_regbank`

## Requirements
- R1: Word index 0 always reads 0x00000010, and writes to it change nothing.
- R2: Status (index 3) holds cause bits NCAUSE-1..0. An `evt_i` bit sets its status bit. A write to index 3 clears every implemented bit written as 1. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: Writing index 4 ORs the written bits into the mask, and writing index 5 removes the written bits from it. The implemented mask bits are 31 (master enable) and NCAUSE-1..0. Indices 4 and 5 both read the mask.
- R4: `irq_o` is high exactly when mask bit 31 is set and some status bit is set whose mask bit is also set.
- R5: In command status (index 2), the stored bits are 3..0 and each is set by writing it as 1; writing 0 leaves it unchanged. Bits 17..16 always read 0. Writing bit 0 as 1 does two things at that edge: it restores every register of the bank to its reset value, and it raises `soft_rst_o` for exactly the following cycle.
- R6: Index 6 stores the written word with bits 7..0 forced to 0. Indices 8, 9, 10 and 11 store it with bits 3..0 forced to 0.
- R7: Index 13 stores the word with bits 15..14 forced to 0. Index 16 keeps bits 13..0 only, and index 17 keeps bits 11..0 only.
- R8: Indices 7, 12, 14 and 15 read `pcur_ed_i`, `done_head_i`, `fm_remain_i` and `fm_num_i` respectively, and writes to them change nothing.
- R9: Index 21 reads `port0_sts_i` with bit 8 forced to 1, and index 22 reads `port1_sts_i` with bit 8 forced to 1. Indices 23 and 24 read 0x00000100. Writes to indices 21 to 24 change nothing.
- R10: After reset the values are as follows. Mask is 0x80000000. Status, command, control, index 6, indices 8 to 11 and index 16 are 0. Index 13 is FI_RST and index 17 is LS_RST.
- R11: Indices 18, 19, 20 and 25 and above read 0, and writes to them change nothing.
- R12: Control (index 1) stores bits 10..0 of the written word. `hcfs_o` equals control bits 7..6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address; word index is addr_i[ADDR_W-1:2] |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Level interrupt |
| hcfs_o | output | 2 | Functional-state field of control |
| soft_rst_o | output | 1 | One-cycle pulse after a reset command |
| evt_i | input | NCAUSE | Per-cause status set pulses |
| pcur_ed_i | input | 32 | Value shown at index 7 |
| done_head_i | input | 32 | Value shown at index 12 |
| fm_remain_i | input | 32 | Value shown at index 14 |
| fm_num_i | input | 32 | Value shown at index 15 |
| port0_sts_i | input | 32 | Port 0 status word |
| port1_sts_i | input | 32 | Port 1 status word |

## Verification
The bench uses the defaults ADDR_W=7 and NCAUSE=7, which gives 32 word indices and seven interrupt causes. With these values it can, from a fresh reset, write all ones to every index and read back every index. This covers all 1024 write/read pairs, so any write that leaks into another register is caught. It also walks each cause bit through set, enable, master-disable and clear, and checks the same-cycle event/clear race and the reset command's pulse and bank-wide restore.

// File: rtl/hc_regbank_pkg.sv
package hc_regbank_pkg;
  localparam int DATA_W = 32;

  localparam int IX_REV    = 0;
  localparam int IX_CTRL   = 1;
  localparam int IX_CMD    = 2;
  localparam int IX_STS    = 3;
  localparam int IX_IEN    = 4;
  localparam int IX_IDIS   = 5;
  localparam int IX_HCCA   = 6;
  localparam int IX_PCUR   = 7;
  localparam int IX_CHEAD  = 8;
  localparam int IX_CCUR   = 9;
  localparam int IX_BHEAD  = 10;
  localparam int IX_BCUR   = 11;
  localparam int IX_DONE   = 12;
  localparam int IX_FIVL   = 13;
  localparam int IX_FREM   = 14;
  localparam int IX_FNUM   = 15;
  localparam int IX_PSTART = 16;
  localparam int IX_LSTH   = 17;
  localparam int IX_PORT0  = 21;
  localparam int IX_PORT1  = 22;
  localparam int IX_PORT2  = 23;
  localparam int IX_PORT3  = 24;

  localparam logic [DATA_W-1:0] REV_VAL   = 32'h0000_0010;
  localparam int                MIE_BIT   = 31;
  localparam int                PPS_BIT   = 8;
  localparam int                HCFS_LSB  = 6;
  localparam int                CMD_W     = 4;
  localparam logic [DATA_W-1:0] PPS_WORD  = DATA_W'(1) << PPS_BIT;

  // Keep-mask of plain stored registers; zero means not a stored register
  function automatic logic [DATA_W-1:0] store_wmask(int ix);
    case (ix)
      IX_CTRL:                           return 32'h0000_07FF;
      IX_HCCA:                           return 32'hFFFF_FF00;
      IX_CHEAD, IX_CCUR, IX_BHEAD, IX_BCUR: return 32'hFFFF_FFF0;
      IX_FIVL:                           return 32'hFFFF_3FFF;
      IX_PSTART:                         return 32'h0000_3FFF;
      IX_LSTH:                           return 32'h0000_0FFF;
      default:                           return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] store_rst(int ix, logic [DATA_W-1:0] fi,
                                                  logic [DATA_W-1:0] ls);
    case (ix)
      IX_FIVL: return fi & store_wmask(ix);
      IX_LSTH: return ls & store_wmask(ix);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/hc_field_reg.sv
module hc_field_reg
  import hc_regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] WMASK   = '1,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (clr_i) q_o <= RST_VAL;
    else if (we_i)  q_o <= wdata_i & WMASK;
  end

  // R6, R7, R12: stored value is the masked write data
  assert_store_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i) |=> (q_o == $past(wdata_i & WMASK)));
endmodule

// File: rtl/hc_irq_unit.sv
module hc_irq_unit
  import hc_regbank_pkg::*;
#(
  parameter int NCAUSE = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sts_we_i,
  input  logic              en_we_i,
  input  logic              dis_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NCAUSE-1:0] evt_i,
  output logic [DATA_W-1:0] sts_o,
  output logic [DATA_W-1:0] msk_o,
  output logic              irq_o
);
  logic [NCAUSE-1:0] sts_q, msk_q, wbits;
  logic              mie_q;
  logic              wdata_unused;

  assign wbits        = wdata_i[NCAUSE-1:0];
  assign wdata_unused = ^wdata_i[MIE_BIT-1:NCAUSE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      msk_q <= '0;
      mie_q <= 1'b1;
    end else if (clr_i) begin
      sts_q <= '0;
      msk_q <= '0;
      mie_q <= 1'b1;
    end else begin
      // event set wins over a same-cycle clear
      sts_q <= (sts_q & ~(sts_we_i ? wbits : '0)) | evt_i;
      if (en_we_i) begin
        msk_q <= msk_q | wbits;
        mie_q <= mie_q | wdata_i[MIE_BIT];
      end else if (dis_we_i) begin
        msk_q <= msk_q & ~wbits;
        mie_q <= mie_q & ~wdata_i[MIE_BIT];
      end
    end
  end

  assign sts_o = DATA_W'(sts_q);
  assign msk_o = {mie_q, (DATA_W - 1 - NCAUSE)'(0), msk_q};
  assign irq_o = mie_q & (|(sts_q & msk_q));

  assert_w1c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && !clr_i) |=> ((sts_o[NCAUSE-1:0] & $past(wbits & ~evt_i)) == '0));
  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i) |=> ((sts_o[NCAUSE-1:0] & $past(evt_i)) == $past(evt_i)));
  assert_en_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_we_i && !clr_i) |=> ((msk_o[NCAUSE-1:0] & $past(wbits)) == $past(wbits)));
  assert_dis_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_we_i && !clr_i) |=> ((msk_o[NCAUSE-1:0] & $past(wbits)) == '0));
  assert_irq_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (msk_o[MIE_BIT] && ((sts_o & msk_o) != '0)));
endmodule

// File: rtl/hc_cmd_unit.sv
module hc_cmd_unit
  import hc_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cmd_o,
  output logic              rst_req_o,
  output logic              soft_rst_o
);
  logic [CMD_W-1:0] cmd_q;
  logic             soft_rst_q;
  logic             wdata_unused;

  assign wdata_unused = ^wdata_i[DATA_W-1:CMD_W];
  assign rst_req_o    = we_i & wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= '0;
      soft_rst_q <= 1'b0;
    end else begin
      soft_rst_q <= rst_req_o;
      if (rst_req_o)  cmd_q <= '0;
      else if (we_i)  cmd_q <= cmd_q | wdata_i[CMD_W-1:0];
    end
  end

  // scheduling-overrun field (17:16) is read-only and held at zero
  assign cmd_o      = DATA_W'(cmd_q);
  assign soft_rst_o = soft_rst_q;

  assert_w1s_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[0]) |=> ((cmd_o & $past(wdata_i & DATA_W'(4'hF)))
                               == $past(wdata_i & DATA_W'(4'hF))));
  assert_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_o) |=> ((cmd_o & $past(cmd_o)) == $past(cmd_o)));
  assert_rst_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> (soft_rst_o && cmd_o == '0));
endmodule

// File: rtl/usb_hc_regbank.sv
module usb_hc_regbank
  import hc_regbank_pkg::*;
#(
  parameter int                ADDR_W = 7,
  parameter int                NCAUSE = 7,
  parameter logic [DATA_W-1:0] FI_RST = 32'h0000_2EDF,
  parameter logic [DATA_W-1:0] LS_RST = 32'h0000_0628
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [1:0]        hcfs_o,
  output logic              soft_rst_o,
  input  logic [NCAUSE-1:0] evt_i,
  input  logic [DATA_W-1:0] pcur_ed_i,
  input  logic [DATA_W-1:0] done_head_i,
  input  logic [DATA_W-1:0] fm_remain_i,
  input  logic [DATA_W-1:0] fm_num_i,
  input  logic [DATA_W-1:0] port0_sts_i,
  input  logic [DATA_W-1:0] port1_sts_i
);
  localparam int IDX_W   = ADDR_W - 2;
  localparam int NUM_IDX = 1 << IDX_W;

  logic [IDX_W-1:0]              idx;
  int                            ix;
  logic                          addr_unused;
  logic                          clr;
  logic [DATA_W-1:0]             cmd_w, sts_w, msk_w;
  logic [NUM_IDX-1:0][DATA_W-1:0] store_q;

  assign idx         = addr_i[ADDR_W-1:2];
  assign ix          = int'(idx);
  assign addr_unused = ^addr_i[1:0];

  hc_cmd_unit u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i && ix == IX_CMD),
    .wdata_i    (wdata_i),
    .cmd_o      (cmd_w),
    .rst_req_o  (clr),
    .soft_rst_o (soft_rst_o)
  );

  hc_irq_unit #(.NCAUSE(NCAUSE)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .sts_we_i (we_i && ix == IX_STS),
    .en_we_i  (we_i && ix == IX_IEN),
    .dis_we_i (we_i && ix == IX_IDIS),
    .wdata_i  (wdata_i),
    .evt_i    (evt_i),
    .sts_o    (sts_w),
    .msk_o    (msk_w),
    .irq_o    (irq_o)
  );

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_store
    if (store_wmask(g) != '0) begin : g_reg
      hc_field_reg #(
        .WMASK   (store_wmask(g)),
        .RST_VAL (store_rst(g, FI_RST, LS_RST))
      ) u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr),
        .we_i    (we_i && ix == g),
        .wdata_i (wdata_i),
        .q_o     (store_q[g])
      );
    end else begin : g_none
      assign store_q[g] = '0;
    end
  end

  assign hcfs_o = store_q[IX_CTRL][HCFS_LSB +: 2];

  always_comb begin
    case (ix)
      IX_REV:             rdata_o = REV_VAL;
      IX_CMD:             rdata_o = cmd_w;
      IX_STS:             rdata_o = sts_w;
      IX_IEN, IX_IDIS:    rdata_o = msk_w;
      IX_PCUR:            rdata_o = pcur_ed_i;
      IX_DONE:            rdata_o = done_head_i;
      IX_FREM:            rdata_o = fm_remain_i;
      IX_FNUM:            rdata_o = fm_num_i;
      IX_PORT0:           rdata_o = port0_sts_i | PPS_WORD;
      IX_PORT1:           rdata_o = port1_sts_i | PPS_WORD;
      IX_PORT2, IX_PORT3: rdata_o = PPS_WORD;
      default:            rdata_o = store_q[idx];
    endcase
  end

  assert_port_power_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ix >= IX_PORT0 && ix <= IX_PORT3) |-> rdata_o[PPS_BIT]);
  assert_hcfs_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ix == IX_CTRL) |=> (hcfs_o == $past(wdata_i[HCFS_LSB +: 2])));
endmodule

// File: tb/usb_hc_regbank_test.sv
`timescale 1ns/1ps
module usb_hc_regbank_test;
  localparam int ADDR_W = 7;
  localparam int NCAUSE = 7;
  localparam int NIDX   = 32;
  localparam logic [31:0] PCUR = 32'h1111_0000, DONE = 32'h2222_0000;
  localparam logic [31:0] FREM = 32'h3333_0000, FNUM = 32'h0000_4444;
  localparam logic [31:0] P0   = 32'h0001_0003, P1 = 32'h0000_0000;

  logic              clk = 1'b0, rst_ni = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0, rdata;
  logic [NCAUSE-1:0] evt = '0;
  logic              irq, soft_rst;
  logic [1:0]        hcfs;
  int                vectors = 0, fails = 0;
  bit                done = 1'b0;

  always #2.5 clk = ~clk;

  usb_hc_regbank uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .irq_o(irq), .hcfs_o(hcfs), .soft_rst_o(soft_rst),
    .evt_i(evt), .pcur_ed_i(PCUR), .done_head_i(DONE), .fm_remain_i(FREM),
    .fm_num_i(FNUM), .port0_sts_i(P0), .port1_sts_i(P1)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic wr(int ix, logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(ix << 2); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int ix, output logic [31:0] d);
    addr = ADDR_W'(ix << 2);
    #0.5 d = rdata;
  endtask

  task automatic pulse_evt(logic [NCAUSE-1:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  function automatic logic [31:0] rst_val(int j);
    case (j)
      0:      return 32'h10;
      4, 5:   return 32'h8000_0000;
      7:      return PCUR;
      12:     return DONE;
      13:     return 32'h2EDF;
      14:     return FREM;
      15:     return FNUM;
      17:     return 32'h628;
      21:     return P0 | 32'h100;
      22:     return P1 | 32'h100;
      23, 24: return 32'h100;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ones_val(int i, int j);
    if (i == 2) return rst_val(j);
    if (j == i || (i inside {4, 5} && j inside {4, 5})) begin
      case (i)
        1:              return 32'h0000_07FF;
        4:              return 32'h8000_007F;
        5:              return 32'h0;
        6:              return 32'hFFFF_FF00;
        8, 9, 10, 11:   return 32'hFFFF_FFF0;
        13:             return 32'hFFFF_3FFF;
        16:             return 32'h0000_3FFF;
        17:             return 32'h0000_0FFF;
        default:        return rst_val(j);
      endcase
    end
    return rst_val(j);
  endfunction

  function automatic string req_of(int j);
    case (j)
      0: return "R1";
      1: return "R12";
      2: return "R5";
      3: return "R2";
      4, 5: return "R3";
      6, 8, 9, 10, 11: return "R6";
      13, 16, 17: return "R7";
      7, 12, 14, 15: return "R8";
      21, 22, 23, 24: return "R9";
      default: return "R11";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d;
    do_reset();
    // R10: reset state of every index
    for (int j = 0; j < NIDX; j++) begin
      rd(j, d);
      chk("R10", d, rst_val(j));
    end
    chk("R10 irq", 32'(irq), 32'h0);
    chk("R10 soft_rst", 32'(soft_rst), 32'h0);

    // all-ones write into each index, then read every index
    for (int i = 0; i < NIDX; i++) begin
      do_reset();
      wr(i, 32'hFFFF_FFFF);
      chk("R5 pulse", 32'(soft_rst), 32'(i == 2));
      for (int j = 0; j < NIDX; j++) begin
        rd(j, d);
        chk(req_of(j), d, ones_val(i, j));
      end
      chk("R4 no status", 32'(irq), 32'h0);
    end

    // R2 R3 R4: each cause through set, enable, master off/on, clear
    for (int b = 0; b < NCAUSE; b++) begin
      do_reset();
      pulse_evt(NCAUSE'(1) << b);
      rd(3, d); chk("R2 set", d, 32'(1) << b);
      chk("R4 masked", 32'(irq), 32'h0);
      wr(4, 32'(1) << b);
      chk("R4 enabled", 32'(irq), 32'h1);
      wr(5, 32'h8000_0000);
      rd(4, d); chk("R3 dis mie", d, 32'(1) << b);
      chk("R4 mie off", 32'(irq), 32'h0);
      wr(4, 32'h8000_0000);
      chk("R4 mie on", 32'(irq), 32'h1);
      wr(3, ~(32'(1) << b));
      rd(3, d); chk("R2 zero-write keeps", d, 32'(1) << b);
      wr(3, 32'(1) << b);
      rd(3, d); chk("R2 w1c", d, 32'h0);
      chk("R4 cleared", 32'(irq), 32'h0);
    end

    // R2: event and clear on same bit in same cycle
    do_reset();
    pulse_evt(7'h06);
    @(negedge clk);
    addr = ADDR_W'(3 << 2); wdata = 32'h6; we = 1'b1; evt = 7'h02;
    @(negedge clk);
    we = 1'b0; evt = '0;
    rd(3, d); chk("R2 set wins", d, 32'h2);

    // R5: write-1-to-set, read-only overrun field
    wr(2, 32'h0000_0006);
    rd(2, d); chk("R5 w1s", d, 32'h6);
    wr(2, 32'h0003_0008);
    rd(2, d); chk("R5 keep+soc", d, 32'hE);

    // R12 then R5 full reset
    wr(1, 32'h0000_00C0);
    chk("R12 hcfs", 32'(hcfs), 32'h3);
    wr(4, 32'h0000_0002);
    wr(2, 32'h0000_0001);
    chk("R5 pulse on", 32'(soft_rst), 32'h1);
    rd(1, d); chk("R5 ctrl restored", d, 32'h0);
    rd(4, d); chk("R5 mask restored", d, 32'h8000_0000);
    rd(3, d); chk("R5 status restored", d, 32'h0);
    rd(2, d); chk("R5 cmd restored", d, 32'h0);
    chk("R12 hcfs restored", 32'(hcfs), 32'h0);
    @(negedge clk);
    chk("R5 pulse off", 32'(soft_rst), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule